// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block carries out the commands a hot-plug driver issues to the slots behind a bridge. A driver writes one command byte together with a slot target. The controller decodes the byte, checks it against the current slot state and updates the per-slot records: slot state, power indicator, attention indicator, latch-open (MRL) flag and presence code. It also keeps a secondary bus speed field and a small command status word.

Every command ends by setting a command-detected flag. Software clears that flag through a clear strobe. When a slot is disabled while its power indicator is off, the slot is treated as emptied: its latch reads open, its presence reads empty, three events are latched and a one-cycle removal pulse is sent out for that slot. The two group commands step through the slots one per clock, and the busy bit stays high for the whole walk.

The slot count is the parameter `NUM_SLOTS` (1 to 31). The `occupied_i` strap sets the state each slot takes on reset.

Top module: `hp_slot_cmd_ctrl`

## Requirements
- R1: In reset, an occupied slot becomes enabled (state 2) with power indicator on (1), latch closed and presence 0. An empty slot becomes disabled (state 3) with power indicator off (3), latch open and presence 3. Status, detected flag, events, removal pulses and bus speed are all zero.
- R2: Codes 0x00–0x3F are slot commands. Bits [1:0] give the requested state (0 keep, 1 power-only, 2 enabled, 3 disabled), bits [3:2] the power indicator and bits [5:4] the attention indicator (0 keep, 1 on, 2 blink, 3 off). A non-zero indicator field is written even when the state request does nothing.
- R3: Disabled goes to power-only or enabled on request, and enabled or power-only goes to disabled on request. A request from enabled to power-only sets invalid-command (status bit 2) and changes no field of the slot. Any other combination leaves the state as it is.
- R4: The target uses only its low 5 bits. Logical target N addresses slot N-1. A target of 0 or above `NUM_SLOTS` sets status bit 2 and changes no slot.
- R5: A move to disabled that leaves the power indicator at off empties the slot. The latch becomes open, presence becomes 3, event bits [2:0] (bit 0 presence, bit 1 latch, bit 2 button) are set, and `removal_o` for that slot is high for exactly one cycle.
- R6: Codes 0x40–0x47 request bus speed code[2:0]. Only 0 is accepted. Any other value sets invalid-mode (status bit 3).
- R7: Code 0x48 (all power-only) and code 0x49 (all enabled) set status bit 2 and change nothing if any slot is enabled when the command arrives.
- R8: An accepted group command visits slot 0 up to slot NUM_SLOTS-1, one per clock, with busy (status bit 0) high for NUM_SLOTS cycles. A slot with its latch closed receives the requested state with power indicator on. A slot with its latch open keeps its state and gets power indicator off.
- R9: Any other code sets status bit 2. Each accepted command first clears the old status bits. Status bit 1 always reads 0.
- R10: Every command sets `cmd_detected_o` when it completes, whether it was valid or not: single commands at the accepting edge, group walks at their last step. `detect_clr_i` clears the flag, but a completion in the same cycle wins.
- R11: A command presented while busy is high is ignored. It leaves no trace in status, slots or the detected flag.
- R12: `evt_clr_i` clears event bits one for one. A bit that is set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| occupied_i | input | NUM_SLOTS | Per-slot occupancy strap used during reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command byte |
| cmd_target_i | input | 8 | Logical slot target (low 5 bits used) |
| detect_clr_i | input | 1 | Clears the command-detected flag |
| evt_clr_i | input | 3*NUM_SLOTS | Per-slot event clear bits |
| cmd_status_o | output | 4 | {invalid mode, invalid command, 0, busy} |
| cmd_detected_o | output | 1 | Command-detected flag |
| bus_speed_o | output | 3 | Secondary bus speed field |
| slot_state_o | output | 2*NUM_SLOTS | Slot state, slot i at [2i+1:2i] |
| pwr_ind_o | output | 2*NUM_SLOTS | Power indicator per slot |
| attn_ind_o | output | 2*NUM_SLOTS | Attention indicator per slot |
| mrl_open_o | output | NUM_SLOTS | Latch-open flag per slot |
| presence_o | output | 2*NUM_SLOTS | Presence code per slot |
| slot_evt_o | output | 3*NUM_SLOTS | Latched events, slot i at [3i+2:3i] |
| removal_o | output | NUM_SLOTS | One-cycle pulse when a slot is emptied |

## Verification
Two functions can act on the detected flag in the same cycle: a command completing, which sets it, and the software clear strobe, which clears it. The bench drives `detect_clr_i` on the same edge that accepts a speed command and expects the flag to read 1 afterwards. One cycle later it drives the clear strobe alone and expects 0. A second overlap is a new command that arrives while a group walk is busy. The bench injects an invalid code in the middle of the walk and then checks that, after the walk ends, the status still shows no invalid-command bit.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;
    // Slot state encodings
    localparam logic [1:0] ST_KEEP = 2'd0;
    localparam logic [1:0] ST_PWR  = 2'd1;
    localparam logic [1:0] ST_ON   = 2'd2;
    localparam logic [1:0] ST_OFF  = 2'd3;
    // Indicator encodings
    localparam logic [1:0] LED_KEEP  = 2'd0;
    localparam logic [1:0] LED_ON    = 2'd1;
    localparam logic [1:0] LED_BLINK = 2'd2;
    localparam logic [1:0] LED_OFF   = 2'd3;
    // Presence code for an empty slot
    localparam logic [1:0] PRES_EMPTY = 2'd3;
    // Event bit positions
    localparam int EVT_PRES = 0;
    localparam int EVT_MRL  = 1;
    localparam int EVT_BTN  = 2;

    typedef enum logic [1:0] {
        K_SLOT  = 2'd0,
        K_SPEED = 2'd1,
        K_GROUP = 2'd2,
        K_BAD   = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/hp_cmd_decode.sv
// Command byte decoder.
// Splits a command byte into its kind and its request fields.
// Assumes: purely combinational; the caller qualifies it with its own strobe.
module hp_cmd_decode
    import hp_cmd_pkg::*;
(
    input  logic [7:0]  code_i,
    output cmd_kind_e   kind_o,
    output logic [1:0]  req_state_o,
    output logic [1:0]  req_pwr_o,
    output logic [1:0]  req_attn_o,
    output logic [2:0]  speed_o,
    output logic [1:0]  grp_state_o
);
    // Classify the opcode range and pull out the fields
    always_comb begin
        if (code_i[7:6] == 2'b00)
            kind_o = K_SLOT;
        else if (code_i[7:3] == 5'b01000)
            kind_o = K_SPEED;
        else if (code_i == 8'h48 || code_i == 8'h49)
            kind_o = K_GROUP;
        else
            kind_o = K_BAD;
        req_state_o = code_i[1:0];
        req_pwr_o   = code_i[3:2];
        req_attn_o  = code_i[5:4];
        speed_o     = code_i[2:0];
        grp_state_o = code_i[0] ? ST_ON : ST_PWR;
    end
endmodule

// File: rtl/hp_slot_unit.sv
// One slot's record and its transition rule.
// Holds state, indicators, latch, presence and events; applies a request
// when apply_i is high and the request is legal.
// Assumes: occupied_i is stable while rst_n is low.
module hp_slot_unit
    import hp_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       occupied_i,
    input  logic       apply_i,
    input  logic [1:0] req_state_i,
    input  logic [1:0] req_pwr_i,
    input  logic [1:0] req_attn_i,
    input  logic [2:0] evt_clr_i,
    output logic [1:0] state_o,
    output logic [1:0] pwr_o,
    output logic [1:0] attn_o,
    output logic       mrl_open_o,
    output logic [1:0] pres_o,
    output logic [2:0] evt_o,
    output logic       illegal_o,
    output logic       removal_o
);
    logic [1:0] state_n, pwr_n, attn_n;
    logic       empty_n, take;

    // Work out the slot's next fields for the current request
    always_comb begin
        illegal_o = (state_o == ST_ON) && (req_state_i == ST_PWR);
        pwr_n     = (req_pwr_i  != LED_KEEP) ? req_pwr_i  : pwr_o;
        attn_n    = (req_attn_i != LED_KEEP) ? req_attn_i : attn_o;
        state_n   = state_o;
        empty_n   = 1'b0;
        if (state_o == ST_OFF && (req_state_i == ST_PWR || req_state_i == ST_ON)) begin
            state_n = req_state_i;
        end else if ((state_o == ST_ON || state_o == ST_PWR) && req_state_i == ST_OFF) begin
            state_n = ST_OFF;
            empty_n = (pwr_n == LED_OFF);
        end
        take = apply_i && !illegal_o;
    end

    // Register the slot record, reset from the occupancy strap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o    <= occupied_i ? ST_ON  : ST_OFF;
            pwr_o      <= occupied_i ? LED_ON : LED_OFF;
            attn_o     <= LED_KEEP;
            mrl_open_o <= !occupied_i;
            pres_o     <= occupied_i ? 2'd0 : PRES_EMPTY;
            evt_o      <= '0;
            removal_o  <= 1'b0;
        end else begin
            removal_o <= take && empty_n;
            evt_o     <= (evt_o & ~evt_clr_i) | ((take && empty_n) ? 3'b111 : 3'b000);
            if (take) begin
                state_o <= state_n;
                pwr_o   <= pwr_n;
                attn_o  <= attn_n;
                if (empty_n) begin
                    mrl_open_o <= 1'b1;
                    pres_o     <= PRES_EMPTY;
                end
            end
        end
    end
endmodule

// File: rtl/hp_slot_cmd_ctrl.sv
// Hot-plug slot command controller top.
// Accepts one command per strobe, runs slot, speed and group commands,
// keeps command status and the command-detected flag.
// Assumes: NUM_SLOTS in 1..31; commands strobed while busy are dropped.
module hp_slot_cmd_ctrl
    import hp_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SLOTS-1:0]   occupied_i,
    input  logic                   cmd_valid_i,
    input  logic [7:0]             cmd_code_i,
    input  logic [7:0]             cmd_target_i,
    input  logic                   detect_clr_i,
    input  logic [3*NUM_SLOTS-1:0] evt_clr_i,
    output logic [3:0]             cmd_status_o,
    output logic                   cmd_detected_o,
    output logic [2:0]             bus_speed_o,
    output logic [2*NUM_SLOTS-1:0] slot_state_o,
    output logic [2*NUM_SLOTS-1:0] pwr_ind_o,
    output logic [2*NUM_SLOTS-1:0] attn_ind_o,
    output logic [NUM_SLOTS-1:0]   mrl_open_o,
    output logic [2*NUM_SLOTS-1:0] presence_o,
    output logic [3*NUM_SLOTS-1:0] slot_evt_o,
    output logic [NUM_SLOTS-1:0]   removal_o
);
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    cmd_kind_e        kind;
    logic [1:0]       dec_state, dec_pwr, dec_attn, dec_grp;
    logic [2:0]       dec_speed;
    logic             busy, inv_cmd, inv_mode;
    logic [IDX_W-1:0] walk_idx;
    logic [1:0]       grp_state;
    logic             accept, tgt_ok, illegal_sel, any_on;
    logic [4:0]       tgt;
    logic [NUM_SLOTS-1:0] apply_v, illegal_v;

    hp_cmd_decode u_dec (
        .code_i      (cmd_code_i),
        .kind_o      (kind),
        .req_state_o (dec_state),
        .req_pwr_o   (dec_pwr),
        .req_attn_o  (dec_attn),
        .speed_o     (dec_speed),
        .grp_state_o (dec_grp)
    );

    // Qualify the strobe and check the target and current slot states
    always_comb begin
        accept      = cmd_valid_i && !busy;
        tgt         = cmd_target_i[4:0];
        tgt_ok      = (tgt != 5'd0) && (int'(tgt) <= NUM_SLOTS);
        illegal_sel = 1'b0;
        any_on      = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (tgt_ok && int'(tgt) == i + 1)
                illegal_sel = illegal_sel | illegal_v[i];
            if (slot_state_o[2*i +: 2] == ST_ON)
                any_on = 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            logic [1:0] rq_state, rq_pwr, rq_attn;

            // Pick this slot's request: group walk step or single command
            always_comb begin
                if (busy) begin
                    apply_v[g] = (walk_idx == IDX_W'(g));
                    rq_state   = mrl_open_o[g] ? ST_KEEP : grp_state;
                    rq_pwr     = mrl_open_o[g] ? LED_OFF : LED_ON;
                    rq_attn    = LED_KEEP;
                end else begin
                    apply_v[g] = accept && (kind == K_SLOT) && tgt_ok && (int'(tgt) == g + 1);
                    rq_state   = dec_state;
                    rq_pwr     = dec_pwr;
                    rq_attn    = dec_attn;
                end
            end

            hp_slot_unit u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .occupied_i  (occupied_i[g]),
                .apply_i     (apply_v[g]),
                .req_state_i (rq_state),
                .req_pwr_i   (rq_pwr),
                .req_attn_i  (rq_attn),
                .evt_clr_i   (evt_clr_i[3*g +: 3]),
                .state_o     (slot_state_o[2*g +: 2]),
                .pwr_o       (pwr_ind_o[2*g +: 2]),
                .attn_o      (attn_ind_o[2*g +: 2]),
                .mrl_open_o  (mrl_open_o[g]),
                .pres_o      (presence_o[2*g +: 2]),
                .evt_o       (slot_evt_o[3*g +: 3]),
                .illegal_o   (illegal_v[g]),
                .removal_o   (removal_o[g])
            );
        end
    endgenerate

    // Sequence commands: status, speed, detected flag and the group walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy           <= 1'b0;
            inv_cmd        <= 1'b0;
            inv_mode       <= 1'b0;
            walk_idx       <= '0;
            grp_state      <= ST_KEEP;
            cmd_detected_o <= 1'b0;
            bus_speed_o    <= 3'd0;
        end else begin
            if (detect_clr_i)
                cmd_detected_o <= 1'b0;
            if (accept) begin
                inv_cmd  <= 1'b0;
                inv_mode <= 1'b0;
                unique case (kind)
                    K_SLOT: begin
                        if (!tgt_ok || illegal_sel)
                            inv_cmd <= 1'b1;
                        cmd_detected_o <= 1'b1;
                    end
                    K_SPEED: begin
                        if (dec_speed == 3'd0)
                            bus_speed_o <= dec_speed;
                        else
                            inv_mode <= 1'b1;
                        cmd_detected_o <= 1'b1;
                    end
                    K_GROUP: begin
                        if (any_on) begin
                            inv_cmd        <= 1'b1;
                            cmd_detected_o <= 1'b1;
                        end else begin
                            busy      <= 1'b1;
                            walk_idx  <= '0;
                            grp_state <= dec_grp;
                        end
                    end
                    default: begin
                        inv_cmd        <= 1'b1;
                        cmd_detected_o <= 1'b1;
                    end
                endcase
            end else if (busy) begin
                if (walk_idx == LAST_IDX) begin
                    busy           <= 1'b0;
                    cmd_detected_o <= 1'b1;
                end else begin
                    walk_idx <= walk_idx + 1'b1;
                end
            end
        end
    end

    assign cmd_status_o = {inv_mode, inv_cmd, 1'b0, busy};
endmodule

// File: rtl/hp_slot_cmd_ctrl_chk.sv
// Property checker for the slot command controller, bound to the top.
// Assumes: observes the top's ports only.
module hp_slot_cmd_ctrl_chk #(
    parameter int NUM_SLOTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid_i,
    input logic [7:0]             cmd_code_i,
    input logic [3:0]             cmd_status_o,
    input logic                   cmd_detected_o,
    input logic [2*NUM_SLOTS-1:0] slot_state_o,
    input logic [NUM_SLOTS-1:0]   mrl_open_o,
    input logic [2*NUM_SLOTS-1:0] presence_o,
    input logic [NUM_SLOTS-1:0]   removal_o
);
    logic [5:0] busy_cnt;

    // Count consecutive busy cycles before the current one
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= '0;
        else
            busy_cnt <= cmd_status_o[0] ? busy_cnt + 1'b1 : 6'd0;
    end

    a_r8_walk_length: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_status_o[0] |-> (int'(busy_cnt) < NUM_SLOTS));

    a_r11_status_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_status_o[0] |=> $stable(cmd_status_o[3:2]));

    a_r10_detect_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !cmd_status_o[0] && cmd_code_i != 8'h48 && cmd_code_i != 8'h49)
        |=> cmd_detected_o);

    a_r6_bad_speed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !cmd_status_o[0] && cmd_code_i[7:3] == 5'b01000 && cmd_code_i[2:0] != 3'd0)
        |=> cmd_status_o[3]);

    a_r9_bit1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> !cmd_status_o[1]);

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
            a_r5_removal_empties: assert property (@(posedge clk) disable iff (!rst_n)
                removal_o[g] |-> (mrl_open_o[g] && presence_o[2*g +: 2] == 2'd3));
            a_r5_removal_single: assert property (@(posedge clk) disable iff (!rst_n)
                removal_o[g] |=> !removal_o[g]);
            a_r3_no_on_to_pwr: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_state_o[2*g +: 2] == 2'd2) |=> (slot_state_o[2*g +: 2] != 2'd1));
        end
    endgenerate
endmodule

bind hp_slot_cmd_ctrl hp_slot_cmd_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_code_i     (cmd_code_i),
    .cmd_status_o   (cmd_status_o),
    .cmd_detected_o (cmd_detected_o),
    .slot_state_o   (slot_state_o),
    .mrl_open_o     (mrl_open_o),
    .presence_o     (presence_o),
    .removal_o      (removal_o)
);

// File: tb/hp_slot_cmd_ctrl_bench.sv
module hp_slot_cmd_ctrl_bench;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   occupied = 4'b0101;
    logic           cmd_valid = 1'b0;
    logic [7:0]     cmd_code = '0;
    logic [7:0]     cmd_target = '0;
    logic           detect_clr = 1'b0;
    logic [3*N-1:0] evt_clr = '0;
    logic [3:0]     status;
    logic           detected;
    logic [2:0]     speed;
    logic [2*N-1:0] st, pwr, attn, pres;
    logic [N-1:0]   mrl, removal;
    logic [3*N-1:0] evt;

    int checks = 0;
    int failures = 0;

    hp_slot_cmd_ctrl #(.NUM_SLOTS(N)) u_hp_slot_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .occupied_i(occupied),
        .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_target_i(cmd_target),
        .detect_clr_i(detect_clr), .evt_clr_i(evt_clr),
        .cmd_status_o(status), .cmd_detected_o(detected), .bus_speed_o(speed),
        .slot_state_o(st), .pwr_ind_o(pwr), .attn_ind_o(attn),
        .mrl_open_o(mrl), .presence_o(pres), .slot_evt_o(evt), .removal_o(removal)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int f2(input logic [2*N-1:0] v, input int i);
        return int'(v[2*i +: 2]);
    endfunction

    // Drive one command for one edge; returns at the following negedge
    task automatic issue(input logic [7:0] code, input logic [7:0] tgt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_target = tgt;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic clr_det();
        @(negedge clk);
        detect_clr = 1'b1;
        @(negedge clk);
        detect_clr = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) begin
            chk("R1", "state", f2(st, i), occupied[i] ? 2 : 3);
            chk("R1", "pwr", f2(pwr, i), occupied[i] ? 1 : 3);
            chk("R1", "mrl", int'(mrl[i]), occupied[i] ? 0 : 1);
            chk("R1", "pres", f2(pres, i), occupied[i] ? 0 : 3);
            chk("R1", "attn", f2(attn, i), 0);
        end
        chk("R1", "status", int'(status), 0);
        chk("R1", "detected", int'(detected), 0);
        chk("R1", "events", int'(evt), 0);
        chk("R1", "removal", int'(removal), 0);
        chk("R1", "speed", int'(speed), 0);
    endtask

    task automatic t_target();
        issue(8'h01, 8'd0);
        chk("R4", "target 0 status", int'(status), 4);
        chk("R10", "detected after bad target", int'(detected), 1);
        chk("R4", "slot0 state kept", f2(st, 0), 2);
        issue(8'h0C, 8'd5);
        chk("R4", "target 5 status", int'(status), 4);
        chk("R4", "pwr unchanged", int'(pwr), int'({2'd3, 2'd1, 2'd3, 2'd1}));
        issue(8'h10, 8'h21);
        chk("R4", "masked target status", int'(status), 0);
        chk("R4", "masked target attn slot0", f2(attn, 0), 1);
    endtask

    task automatic t_illegal();
        issue(8'h29, 8'd3);
        chk("R3", "on->pwr status", int'(status), 4);
        chk("R3", "on->pwr state", f2(st, 2), 2);
        chk("R3", "on->pwr pwr ind", f2(pwr, 2), 1);
        chk("R3", "on->pwr attn ind", f2(attn, 2), 0);
    endtask

    task automatic t_indicators();
        issue(8'h28, 8'd3);
        chk("R2", "status", int'(status), 0);
        chk("R2", "pwr blink", f2(pwr, 2), 2);
        chk("R2", "attn blink", f2(attn, 2), 2);
        chk("R2", "state kept", f2(st, 2), 2);
        issue(8'h02, 8'd3);
        chk("R3", "on->on kept", f2(st, 2), 2);
        chk("R2", "zero fields keep pwr", f2(pwr, 2), 2);
    endtask

    task automatic t_group_fail();
        clr_det();
        issue(8'h49, 8'd0);
        chk("R7", "status", int'(status), 4);
        chk("R7", "slot1 pwr kept", f2(pwr, 1), 3);
        chk("R7", "slot0 state kept", f2(st, 0), 2);
        chk("R10", "detected", int'(detected), 1);
    endtask

    task automatic t_transitions();
        issue(8'h07, 8'd3);
        chk("R3", "on->off", f2(st, 2), 3);
        chk("R5", "pwr on keeps latch", int'(mrl[2]), 0);
        chk("R5", "pwr on keeps presence", f2(pres, 2), 0);
        chk("R5", "no removal", int'(removal), 0);
        issue(8'h02, 8'd3);
        chk("R3", "off->on", f2(st, 2), 2);
        issue(8'h03, 8'd3);
        issue(8'h01, 8'd3);
        chk("R3", "off->pwr", f2(st, 2), 1);
        issue(8'h03, 8'd3);
        chk("R3", "pwr->off", f2(st, 2), 3);
    endtask

    task automatic t_empty();
        issue(8'h0F, 8'd1);
        chk("R5", "state", f2(st, 0), 3);
        chk("R5", "latch open", int'(mrl[0]), 1);
        chk("R5", "presence", f2(pres, 0), 3);
        chk("R5", "events", int'(evt[2:0]), 7);
        chk("R5", "removal pulse", int'(removal), 1);
        @(negedge clk);
        chk("R5", "removal ends", int'(removal), 0);
        evt_clr[2:0] = 3'b010;
        @(negedge clk);
        evt_clr = '0;
        chk("R12", "event clear", int'(evt[2:0]), 5);
    endtask

    task automatic t_speed();
        issue(8'h40, 8'd0);
        chk("R6", "speed 0 status", int'(status), 0);
        chk("R6", "speed field", int'(speed), 0);
        issue(8'h46, 8'd0);
        chk("R6", "speed 6 status", int'(status), 8);
        chk("R6", "speed field kept", int'(speed), 0);
        issue(8'h4A, 8'd0);
        chk("R9", "unknown code", int'(status), 4);
        issue(8'h40, 8'd0);
        chk("R9", "status cleared", int'(status), 0);
    endtask

    task automatic t_group();
        clr_det();
        issue(8'h49, 8'd0);
        chk("R8", "busy", int'(status), 1);
        chk("R10", "not yet detected", int'(detected), 0);
        // walk edge 1, with an ignored command alongside
        cmd_valid = 1'b1; cmd_code = 8'h4A; cmd_target = 8'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8", "slot0 open pwr off", f2(pwr, 0), 3);
        chk("R8", "slot0 open state kept", f2(st, 0), 3);
        @(negedge clk);
        chk("R8", "still busy", int'(status[0]), 1);
        @(negedge clk);
        chk("R8", "slot2 closed enabled", f2(st, 2), 2);
        chk("R8", "slot2 pwr on", f2(pwr, 2), 1);
        chk("R8", "busy before last", int'(status[0]), 1);
        @(negedge clk);
        chk("R8", "busy done", int'(status[0]), 0);
        chk("R11", "ignored cmd left status", int'(status), 0);
        chk("R10", "detected at end", int'(detected), 1);
        chk("R8", "slot3 state kept", f2(st, 3), 3);
    endtask

    task automatic t_detect();
        clr_det();
        chk("R10", "cleared", int'(detected), 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h40; detect_clr = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; detect_clr = 1'b0;
        chk("R10", "set wins", int'(detected), 1);
        clr_det();
        chk("R10", "clear alone", int'(detected), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_target();
                t_illegal();
                t_indicators();
                t_group_fail();
                t_transitions();
                t_empty();
                t_speed();
                t_group();
                t_detect();
            end
            begin
                repeat (5000) @(negedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule